// File: doc/BRIEF.md
# Execution Unit Occupancy Scoreboard

This block decides, cycle by cycle, whether an operation may be issued to one of four execution units: two integer units (indices 0 and 1) and two floating-point units (indices 2 and 3). Each cycle it sees two issue requests. Port 0 holds the older operation in program order and port 1 the younger. Each request carries an operation code, a target unit, a destination register tag and two source register tags. A request is granted in the same cycle only if three things hold: its target unit may run that operation, the unit is free, and both source results are ready.

When a request is granted, the scoreboard loads a down-counter for the unit with the number of cycles the operation holds it. It also loads two down-counters for the destination register with the result latency. One of these is the latency seen by ordinary consumers. The other is the latency seen by branch and condition consumers, which is longer after compare-type producers. Every counter drops by one per cycle, and a resource counts as available once its counter reads zero. Register renaming, arithmetic and memory access are handled elsewhere.

Top module: `exec_occ_scoreboard`

## Requirements
- R1: After reset all four units are free (`unit_busy` = 0) and all registers are ready. A legal request with any sources is granted in the first cycle after reset.
- R2: Integer codes: 0 plain integer op (hold 1, latency 2), 1 compare (hold 1, latency 3), 2 recording compare (hold 1, latency 2). They may use integer unit 0 or 1.
- R3: Multiply codes on integer units: 3 short (hold 3, latency 4), 4 32-bit (hold 4, latency 5), 5 64-bit (hold 6, latency 7), 6 32-bit with compare (hold 4, latency 5), 7 64-bit with compare (hold 6, latency 7).
- R4: Code 8 is a 32-bit divide (hold 35, latency 36) and code 9 is a 64-bit divide (hold 67, latency 68). Both are granted only when the target unit is 1. A divide aimed at unit 0 is never granted and leaves no state.
- R5: Code 10 is a special-register move (hold 1, latency 3). It is granted only on unit 0. Aimed at unit 1 it is never granted.
- R6: Floating-point codes on units 2 or 3: 11 basic op (hold 1, latency 6), 12 compare (hold 1, latency 5), 13 divide (hold 28, latency 33), 14 square root (hold 35, latency 40).
- R7: Code 15 is a branch or condition consumer. It uses no unit and writes no register. It waits 4 cycles after a recording compare, 8 after a 32-bit multiply-compare, 10 after a 64-bit multiply-compare, and the ordinary latency after any other producer.
- R8: Once an operation holding a unit for H cycles is granted in cycle t, the next operation on that unit is granted no earlier than, and exactly at, cycle t+H if it is waiting. A consumer of its result with latency L is granted at cycle t+L.
- R9: When both ports target the same free unit in one cycle, port 0 is granted and port 1 is stalled.
- R10: Port 1 is stalled whenever port 0 is valid and not granted. Port 1 is also stalled when it reads the register that a granted port 0 writes in the same cycle. Otherwise both ports may be granted in one cycle.
- R11: Unit indices 0 and 1 take only integer codes (0 to 10), and 2 and 3 take only floating-point codes (11 to 14). A request that breaks this is never granted and does not change `unit_busy`.
- R12: `unit_busy[u]` is 1 exactly while unit u holds an operation. For a hold of H granted in cycle t, it reads 1 from t+1 to t+H-1 and 0 from t+H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req0_valid | input | 1 | Older request present |
| req0_op | input | 4 | Older request operation code |
| req0_unit | input | 2 | Older request target unit |
| req0_dst | input | TAG_W | Older request destination tag |
| req0_src_a | input | TAG_W | Older request first source tag |
| req0_src_b | input | TAG_W | Older request second source tag |
| req1_valid | input | 1 | Younger request present |
| req1_op | input | 4 | Younger request operation code |
| req1_unit | input | 2 | Younger request target unit |
| req1_dst | input | TAG_W | Younger request destination tag |
| req1_src_a | input | TAG_W | Younger request first source tag |
| req1_src_b | input | TAG_W | Younger request second source tag |
| gnt0 | output | 1 | Older request issued this cycle |
| gnt1 | output | 1 | Younger request issued this cycle |
| unit_busy | output | 4 | Per-unit occupied flags |

## Verification
Two cases can land in one cycle. In the first, both ports claim the same free unit. In the second, the younger port reads the register the older port is writing. The bench sets up each case by driving both ports in a single cycle. It then judges the grant pair on both ports, and the retry on the following cycles, against the priority and stall rules. It also sweeps every operation code, measuring the cycle in which a same-unit follower, an ordinary consumer and a branch consumer are first granted.

// File: rtl/eos_pkg.sv
package eos_pkg;
  localparam int CNT_W  = 7;
  localparam int NUNITS = 4;
  localparam int UNIT_W = $clog2(NUNITS);

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_CMP    = 4'd1,
    OP_RCMP   = 4'd2,
    OP_MULS   = 4'd3,
    OP_MUL32  = 4'd4,
    OP_MUL64  = 4'd5,
    OP_MULC32 = 4'd6,
    OP_MULC64 = 4'd7,
    OP_DIV32  = 4'd8,
    OP_DIV64  = 4'd9,
    OP_SPR    = 4'd10,
    OP_FADD   = 4'd11,
    OP_FCMP   = 4'd12,
    OP_FDIV   = 4'd13,
    OP_FSQRT  = 4'd14,
    OP_BR     = 4'd15
  } op_e;

  typedef enum logic [1:0] {CL_INT = 2'd0, CL_FP = 2'd1, CL_NONE = 2'd2} ucls_e;

  typedef struct packed {
    ucls_e             cls;
    logic              fixed;
    logic [UNIT_W-1:0] fixed_unit;
    logic [CNT_W-1:0]  hold;
    logic [CNT_W-1:0]  lat;
    logic [CNT_W-1:0]  brlat;
  } op_info_t;

  function automatic op_info_t mk(ucls_e c, logic f, logic [UNIT_W-1:0] fu,
                                  int h, int l, int b);
    op_info_t r;
    r.cls        = c;
    r.fixed      = f;
    r.fixed_unit = fu;
    r.hold       = CNT_W'(h);
    r.lat        = CNT_W'(l);
    r.brlat      = CNT_W'(b);
    return r;
  endfunction

  function automatic op_info_t op_info(logic [3:0] op);
    op_info_t r;
    case (op)
      OP_ADD:    r = mk(CL_INT, 1'b0, 2'd0, 1, 2, 2);
      OP_CMP:    r = mk(CL_INT, 1'b0, 2'd0, 1, 3, 3);
      OP_RCMP:   r = mk(CL_INT, 1'b0, 2'd0, 1, 2, 4);
      OP_MULS:   r = mk(CL_INT, 1'b0, 2'd0, 3, 4, 4);
      OP_MUL32:  r = mk(CL_INT, 1'b0, 2'd0, 4, 5, 5);
      OP_MUL64:  r = mk(CL_INT, 1'b0, 2'd0, 6, 7, 7);
      OP_MULC32: r = mk(CL_INT, 1'b0, 2'd0, 4, 5, 8);
      OP_MULC64: r = mk(CL_INT, 1'b0, 2'd0, 6, 7, 10);
      OP_DIV32:  r = mk(CL_INT, 1'b1, 2'd1, 35, 36, 36);
      OP_DIV64:  r = mk(CL_INT, 1'b1, 2'd1, 67, 68, 68);
      OP_SPR:    r = mk(CL_INT, 1'b1, 2'd0, 1, 3, 3);
      OP_FADD:   r = mk(CL_FP, 1'b0, 2'd0, 1, 6, 6);
      OP_FCMP:   r = mk(CL_FP, 1'b0, 2'd0, 1, 5, 5);
      OP_FDIV:   r = mk(CL_FP, 1'b0, 2'd0, 28, 33, 33);
      OP_FSQRT:  r = mk(CL_FP, 1'b0, 2'd0, 35, 40, 40);
      default:   r = mk(CL_NONE, 1'b0, 2'd0, 1, 1, 1);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/eos_unit_timer.sv
module eos_unit_timer
  import eos_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] hold,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= hold - CNT_W'(1);
    else if (cnt != '0) cnt <= cnt - CNT_W'(1);
  end

  assign busy = (cnt != '0);

  // R8: an occupied unit steps down by exactly one each cycle
  p_count_down_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
  // R8: a new occupant is only loaded into an idle unit
  p_load_idle_r8: assert property (@(posedge clk) disable iff (rst)
    load |-> (cnt == '0));
endmodule

// File: rtl/eos_reg_timer.sv
module eos_reg_timer
  import eos_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int NPORTS = 2,
  localparam int TAG_W = $clog2(NREGS)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en    [NPORTS],
  input  logic [TAG_W-1:0] wr_tag   [NPORTS],
  input  logic [CNT_W-1:0] wr_lat   [NPORTS],
  input  logic [CNT_W-1:0] wr_brlat [NPORTS],
  output logic [NREGS-1:0] rdy,
  output logic [NREGS-1:0] br_rdy
);
  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic [CNT_W-1:0] cnt, bcnt;
    logic             hit;
    logic [CNT_W-1:0] nl, nb;

    always_comb begin
      hit = 1'b0;
      nl  = '0;
      nb  = '0;
      for (int p = 0; p < NPORTS; p++) begin
        if (wr_en[p] && wr_tag[p] == TAG_W'(r)) begin
          hit = 1'b1;
          nl  = wr_lat[p] - CNT_W'(1);
          nb  = wr_brlat[p] - CNT_W'(1);
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt  <= '0;
        bcnt <= '0;
      end else if (hit) begin
        cnt  <= nl;
        bcnt <= nb;
      end else begin
        if (cnt != '0)  cnt  <= cnt - CNT_W'(1);
        if (bcnt != '0) bcnt <= bcnt - CNT_W'(1);
      end
    end

    assign rdy[r]    = (cnt == '0);
    assign br_rdy[r] = (bcnt == '0);

    // R7: the branch view of a result is never ready before the ordinary view
    p_br_after_norm_r7: assert property (@(posedge clk) disable iff (rst)
      (bcnt >= cnt));
  end
endmodule

// File: rtl/eos_issue_arb.sv
module eos_issue_arb
  import eos_pkg::*;
#(
  parameter int NREGS = 16,
  localparam int TAG_W = $clog2(NREGS)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid [2],
  input  logic [3:0]        op    [2],
  input  logic [UNIT_W-1:0] unit  [2],
  input  logic [TAG_W-1:0]  dst   [2],
  input  logic [TAG_W-1:0]  src_a [2],
  input  logic [TAG_W-1:0]  src_b [2],
  input  logic [NUNITS-1:0] unit_busy,
  input  logic [NREGS-1:0]  rdy,
  input  logic [NREGS-1:0]  br_rdy,
  output logic              gnt   [2],
  output op_info_t          info  [2],
  output logic              is_br [2]
);
  logic can [2];

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic cls_ok, fix_ok, unit_ok, src_ok;
    always_comb begin
      info[p]  = op_info(op[p]);
      is_br[p] = (info[p].cls == CL_NONE);
      cls_ok   = is_br[p]
               || (info[p].cls == CL_INT && unit[p] < UNIT_W'(2))
               || (info[p].cls == CL_FP  && unit[p] >= UNIT_W'(2));
      fix_ok   = !info[p].fixed || (unit[p] == info[p].fixed_unit);
      unit_ok  = is_br[p] || !unit_busy[unit[p]];
      src_ok   = is_br[p] ? (br_rdy[src_a[p]] && br_rdy[src_b[p]])
                          : (rdy[src_a[p]] && rdy[src_b[p]]);
      can[p]   = valid[p] && cls_ok && fix_ok && unit_ok && src_ok;
    end
  end

  logic same_unit, raw_hit;
  always_comb begin
    same_unit = !is_br[0] && !is_br[1] && (unit[0] == unit[1]);
    raw_hit   = !is_br[0] && ((dst[0] == src_a[1]) || (dst[0] == src_b[1]));
    gnt[0]    = can[0];
    gnt[1]    = can[1] && (!valid[0] || gnt[0])
                && !(gnt[0] && (same_unit || raw_hit));
  end

  // R9: two issued operations never share a unit
  p_one_per_unit_r9: assert property (@(posedge clk) disable iff (rst)
    (gnt[0] && gnt[1] && !is_br[0] && !is_br[1]) |-> (unit[0] != unit[1]));
  // R10: the younger port never overtakes a waiting older one
  p_in_order_r10: assert property (@(posedge clk) disable iff (rst)
    (gnt[1] && valid[0]) |-> gnt[0]);
  // R4: divides only ever issue on integer unit 1
  p_div_unit_r4: assert property (@(posedge clk) disable iff (rst)
    (gnt[0] && (op[0] == OP_DIV32 || op[0] == OP_DIV64)) |-> (unit[0] == UNIT_W'(1)));
  // R5: special-register moves only ever issue on integer unit 0
  p_spr_unit_r5: assert property (@(posedge clk) disable iff (rst)
    (gnt[1] && op[1] == OP_SPR) |-> (unit[1] == UNIT_W'(0)));
endmodule

// File: rtl/exec_occ_scoreboard.sv
module exec_occ_scoreboard
  import eos_pkg::*;
#(
  parameter int NREGS = 16,
  localparam int TAG_W = $clog2(NREGS)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req0_valid,
  input  logic [3:0]        req0_op,
  input  logic [1:0]        req0_unit,
  input  logic [TAG_W-1:0]  req0_dst,
  input  logic [TAG_W-1:0]  req0_src_a,
  input  logic [TAG_W-1:0]  req0_src_b,
  input  logic              req1_valid,
  input  logic [3:0]        req1_op,
  input  logic [1:0]        req1_unit,
  input  logic [TAG_W-1:0]  req1_dst,
  input  logic [TAG_W-1:0]  req1_src_a,
  input  logic [TAG_W-1:0]  req1_src_b,
  output logic              gnt0,
  output logic              gnt1,
  output logic [NUNITS-1:0] unit_busy
);
  logic              valid [2];
  logic [3:0]        op    [2];
  logic [UNIT_W-1:0] unit  [2];
  logic [TAG_W-1:0]  dst   [2];
  logic [TAG_W-1:0]  src_a [2];
  logic [TAG_W-1:0]  src_b [2];
  logic              gnt   [2];
  op_info_t          info  [2];
  logic              is_br [2];
  logic [NREGS-1:0]  rdy, br_rdy;

  assign valid = '{req0_valid, req1_valid};
  assign op    = '{req0_op, req1_op};
  assign unit  = '{req0_unit, req1_unit};
  assign dst   = '{req0_dst, req1_dst};
  assign src_a = '{req0_src_a, req1_src_a};
  assign src_b = '{req0_src_b, req1_src_b};

  eos_issue_arb #(.NREGS(NREGS)) u_arb (
    .clk(clk), .rst(rst), .valid(valid), .op(op), .unit(unit), .dst(dst),
    .src_a(src_a), .src_b(src_b), .unit_busy(unit_busy), .rdy(rdy),
    .br_rdy(br_rdy), .gnt(gnt), .info(info), .is_br(is_br)
  );

  assign gnt0 = gnt[0];
  assign gnt1 = gnt[1];

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    logic             ld;
    logic [CNT_W-1:0] hv;
    always_comb begin
      ld = 1'b0;
      hv = '0;
      for (int p = 0; p < 2; p++) begin
        if (gnt[p] && !is_br[p] && unit[p] == UNIT_W'(u)) begin
          ld = 1'b1;
          hv = info[p].hold;
        end
      end
    end
    eos_unit_timer u_tmr (
      .clk(clk), .rst(rst), .load(ld), .hold(hv), .busy(unit_busy[u])
    );
  end

  logic             wr_en    [2];
  logic [CNT_W-1:0] wr_lat   [2];
  logic [CNT_W-1:0] wr_brlat [2];
  always_comb begin
    for (int p = 0; p < 2; p++) begin
      wr_en[p]    = gnt[p] && !is_br[p];
      wr_lat[p]   = info[p].lat;
      wr_brlat[p] = info[p].brlat;
    end
  end

  eos_reg_timer #(.NREGS(NREGS), .NPORTS(2)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tag(dst), .wr_lat(wr_lat),
    .wr_brlat(wr_brlat), .rdy(rdy), .br_rdy(br_rdy)
  );

  // R8: an operation is only issued into a unit that is not occupied
  p_issue_free_r8: assert property (@(posedge clk) disable iff (rst)
    (gnt0 && !is_br[0]) |-> !unit_busy[req0_unit]);
  // R12: a granted multi-cycle occupant shows its unit as busy next cycle
  p_busy_after_issue_r12: assert property (@(posedge clk) disable iff (rst)
    (gnt0 && !is_br[0] && info[0].hold > CNT_W'(1)) |=> unit_busy[$past(req0_unit)]);
endmodule

// File: tb/exec_occ_scoreboard_test.sv
`timescale 1ns/1ps
module exec_occ_scoreboard_test;
  localparam int NREGS = 16;
  localparam int TW = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          v0, v1;
  logic [3:0]    o0, o1;
  logic [1:0]    u0, u1;
  logic [TW-1:0] d0, a0, b0, d1, a1, b1;
  logic          g0, g1;
  logic [3:0]    busy;

  exec_occ_scoreboard #(.NREGS(NREGS)) uut (
    .clk(clk), .rst(rst),
    .req0_valid(v0), .req0_op(o0), .req0_unit(u0), .req0_dst(d0),
    .req0_src_a(a0), .req0_src_b(b0),
    .req1_valid(v1), .req1_op(o1), .req1_unit(u1), .req1_dst(d1),
    .req1_src_a(a1), .req1_src_b(b1),
    .gnt0(g0), .gnt1(g1), .unit_busy(busy)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set0(logic v, int op, int un, int d, int a, int b);
    v0 = v; o0 = 4'(op); u0 = 2'(un); d0 = TW'(d); a0 = TW'(a); b0 = TW'(b);
  endtask
  task automatic set1(logic v, int op, int un, int d, int a, int b);
    v1 = v; o1 = 4'(op); u1 = 2'(un); d1 = TW'(d); a1 = TW'(a); b1 = TW'(b);
  endtask

  task automatic idle(int n);
    set0(0, 0, 0, 0, 0, 0);
    set1(0, 0, 0, 0, 0, 0);
    repeat (n) step();
  endtask

  // expected hold / latency / branch latency from the requirements
  function automatic void exp_of(int op, output int h, output int l, output int bl);
    case (op)
      0: begin h = 1;  l = 2;  bl = 2;  end
      1: begin h = 1;  l = 3;  bl = 3;  end
      2: begin h = 1;  l = 2;  bl = 4;  end
      3: begin h = 3;  l = 4;  bl = 4;  end
      4: begin h = 4;  l = 5;  bl = 5;  end
      5: begin h = 6;  l = 7;  bl = 7;  end
      6: begin h = 4;  l = 5;  bl = 8;  end
      7: begin h = 6;  l = 7;  bl = 10; end
      8: begin h = 35; l = 36; bl = 36; end
      9: begin h = 67; l = 68; bl = 68; end
      10: begin h = 1; l = 3;  bl = 3;  end
      11: begin h = 1; l = 6;  bl = 6;  end
      12: begin h = 1; l = 5;  bl = 5;  end
      13: begin h = 28; l = 33; bl = 33; end
      default: begin h = 35; l = 40; bl = 40; end
    endcase
  endfunction

  function automatic string tag_of(int op);
    if (op <= 2) return "R2";
    if (op <= 7) return "R3";
    if (op <= 9) return "R4";
    if (op == 10) return "R5";
    return "R6";
  endfunction

  // issue producer on port 0 and count cycles until a probe is granted
  task automatic probe(int pop, int pun, int cop, int cun, int csrc, string tg,
                       output int k);
    set0(1, pop, pun, 5, 0, 0);
    #1;
    chk({tg, " producer grant"}, int'(g0), 1);
    step();
    k = 1;
    for (int i = 0; i < 100; i++) begin
      set0(1, cop, cun, 9, csrc, csrc);
      #1;
      if (g0) break;
      step();
      k++;
    end
    step();
    idle(75);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int k, h, l, bl, un, cu, cop;
    set0(0, 0, 0, 0, 0, 0);
    set1(0, 0, 0, 0, 0, 0);
    repeat (3) step();
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 busy after reset", int'(busy), 0);
    set0(1, 15, 0, 0, 3, 7);
    set1(1, 0, 1, 4, 9, 12);
    #1;
    chk("R1 branch grant after reset", int'(g0), 1);
    chk("R1 op grant after reset", int'(g1), 1);
    step();
    idle(5);

    // per-op sweep: R8 hold, ordinary latency, R7 branch latency
    for (int op = 0; op < 15; op++) begin
      exp_of(op, h, l, bl);
      un = (op == 8 || op == 9) ? 1 : (op >= 11 ? 2 : 0);
      cop = (op >= 11) ? 11 : 0;
      probe(op, un, cop, un, 0, "R8", k);
      chk({"R8 hold ", tag_of(op)}, k, h);
      cu = (op >= 11) ? 0 : 3;
      cop = (op >= 11) ? 0 : 11;
      probe(op, un, cop, cu, 5, tag_of(op), k);
      chk({tag_of(op), " latency"}, k, l);
      probe(op, un, 15, 0, 5, "R7", k);
      chk("R7 branch latency", k, bl);
    end

    // R4 / R5 / R11 illegal targets never granted, no busy change
    set0(1, 8, 0, 5, 0, 0); #1; chk("R4 div on unit0", int'(g0), 0); step();
    set0(1, 9, 0, 5, 0, 0); #1; chk("R4 div64 on unit0", int'(g0), 0); step();
    set0(1, 10, 1, 5, 0, 0); #1; chk("R5 spr on unit1", int'(g0), 0); step();
    set0(1, 11, 0, 5, 0, 0); #1; chk("R11 fp op on int unit", int'(g0), 0); step();
    set0(1, 4, 3, 5, 0, 0); #1; chk("R11 int op on fp unit", int'(g0), 0); step();
    chk("R11 busy unchanged", int'(busy), 0);
    idle(2);

    // R9 same unit in one cycle
    set0(1, 4, 0, 6, 0, 0);
    set1(1, 0, 0, 7, 0, 0);
    #1;
    chk("R9 older wins", int'(g0), 1);
    chk("R9 younger stalled", int'(g1), 0);
    step();
    chk("R12 busy after mul", int'(busy), 1);
    idle(10);

    // R10 different units both issue
    set0(1, 0, 0, 6, 0, 0);
    set1(1, 11, 2, 7, 0, 0);
    #1;
    chk("R10 both granted", int'(g0) + int'(g1), 2);
    step();
    idle(10);

    // R10 younger reads older's same-cycle destination
    set0(1, 0, 0, 6, 0, 0);
    set1(1, 0, 1, 7, 6, 0);
    #1;
    chk("R10 raw stall older", int'(g0), 1);
    chk("R10 raw stall younger", int'(g1), 0);
    step();
    idle(10);

    // R10 older waiting blocks younger
    set0(1, 5, 1, 8, 0, 0);
    #1;
    chk("R10 setup grant", int'(g0), 1);
    step();
    set0(1, 0, 0, 6, 8, 8);
    set1(1, 11, 2, 7, 0, 0);
    #1;
    chk("R10 older waits", int'(g0), 0);
    chk("R10 younger blocked", int'(g1), 0);
    step();
    idle(10);

    // R12 busy window for a 67-cycle hold on unit 1
    set0(1, 9, 1, 5, 0, 0);
    #1;
    chk("R12 div issue", int'(g0), 1);
    step();
    set0(0, 0, 0, 0, 0, 0);
    #1;
    chk("R12 busy first cycle", int'(busy), 2);
    repeat (65) step();
    #1;
    chk("R12 busy last cycle", int'(busy), 2);
    step();
    #1;
    chk("R12 free at hold end", int'(busy), 0);
    idle(75);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule